// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block raises a doorbell interrupt from one port of a shared two-port memory toward the other. It watches the access signals of both ports. Two words at the top of the shared address space serve as mailboxes. The highest address minus one belongs to the left port, and the highest address belongs to the right port.

A write by one port into the other port's mailbox raises that other port's interrupt flag. The flag stays raised until its owner reads its own mailbox. The mailbox data itself lives in the normal memory array, and this block only tracks the two flags. Each flag appears as an active-low output that is driven both high and low.

All inputs are sampled on the rising clock edge. A flag changes on the edge where its qualifying access is seen, and its output is visible from then on. An access counts only when that port's chip enable is high and its semaphore select is low. The block uses no data stream, so it has no valid/ready handshake. All pins are plain control and status pins.

Top module: `mbx_irq_top`

## Requirements
- R1: A right-port write (`r_wr`=1) to address 2^ADDR_W-2 (0x1FFE by default) drives `l_int_n` low from the clock edge that samples it.
- R2: A left-port read (`l_wr`=0) of address 2^ADDR_W-2 drives `l_int_n` high from the clock edge that samples it, unless R1 also applies on that edge.
- R3: A left-port write (`l_wr`=1) to address 2^ADDR_W-1 (0x1FFF by default) drives `r_int_n` low from the clock edge that samples it.
- R4: A right-port read (`r_wr`=0) of address 2^ADDR_W-1 drives `r_int_n` high from the clock edge that samples it, unless R3 also applies on that edge.
- R5: When a set and a clear of the same flag are sampled on one edge, the flag ends up set (output low).
- R6: An access with chip enable low, or with semaphore select high, neither sets nor clears any flag.
- R7: Either flag is left unchanged by all of the following accesses:
  - accesses to other addresses;
  - a port writing its own mailbox;
  - a port reading the other port's mailbox.
- R8: While the synchronous active-low reset `rst_n` is low, both outputs are driven high on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| l_addr | input | ADDR_W | Left port address |
| l_ce | input | 1 | Left chip enable, active high |
| l_sem | input | 1 | Left semaphore select, active high (blocks mailbox action) |
| l_wr | input | 1 | Left direction: 1 write, 0 read |
| r_addr | input | ADDR_W | Right port address |
| r_ce | input | 1 | Right chip enable, active high |
| r_sem | input | 1 | Right semaphore select, active high |
| r_wr | input | 1 | Right direction: 1 write, 0 read |
| l_int_n | output | 1 | Left interrupt, active low |
| r_int_n | output | 1 | Right interrupt, active low |

## Verification
The same flag can be set by one port and cleared by the other on a single edge. For example, the right port writes 0x1FFE while the left port reads 0x1FFE. The bench drives such paired accesses directly, and it also produces them often through random stimulus that favours the two mailbox addresses. The result is judged against a behavioural model in which the set takes precedence, and both outputs are compared after every edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [0:0] { SIDE_L = 1'b0, SIDE_R = 1'b1 } side_e;

  function automatic logic [31:0] box_addr(input int addr_w, input side_e side);
    logic [31:0] top;
    top = (32'd1 << addr_w) - 32'd1;
    return (side == SIDE_L) ? top - 32'd1 : top;
  endfunction
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int ADDR_W = 13,
  parameter mbx_pkg::side_e SIDE = mbx_pkg::SIDE_L
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce,
  input  logic              sem,
  input  logic              wr,
  output logic              post_peer,
  output logic              take_own
);
  import mbx_pkg::*;
  localparam side_e PEER = (SIDE == SIDE_L) ? SIDE_R : SIDE_L;
  localparam logic [31:0] OWN_W  = box_addr(ADDR_W, SIDE);
  localparam logic [31:0] PEER_W = box_addr(ADDR_W, PEER);
  localparam logic [ADDR_W-1:0] OWN_BOX  = OWN_W[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] PEER_BOX = PEER_W[ADDR_W-1:0];

  logic active;
  assign active    = ce & ~sem;
  assign post_peer = active &  wr & (addr == PEER_BOX);
  assign take_own  = active & ~wr & (addr == OWN_BOX);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (set) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  assign irq_n = ~pend_q;
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_ce,
  input  logic              l_sem,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_ce,
  input  logic              r_sem,
  input  logic              r_wr,
  output logic              l_int_n,
  output logic              r_int_n
);
  import mbx_pkg::*;
  localparam int NPORT = 2;

  logic [ADDR_W-1:0] addr_a [NPORT];
  logic [NPORT-1:0]  ce_a, sem_a, wr_a, post_a, take_a, irq_a;

  assign addr_a[0] = l_addr;
  assign addr_a[1] = r_addr;
  assign ce_a  = {r_ce, l_ce};
  assign sem_a = {r_sem, l_sem};
  assign wr_a  = {r_wr, l_wr};

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    localparam side_e S = (i == 0) ? SIDE_L : SIDE_R;
    mbx_port_decode #(.ADDR_W(ADDR_W), .SIDE(S)) u_dec (
      .addr(addr_a[i]), .ce(ce_a[i]), .sem(sem_a[i]), .wr(wr_a[i]),
      .post_peer(post_a[i]), .take_own(take_a[i])
    );
    mbx_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(post_a[NPORT-1-i]), .clr(take_a[i]),
      .irq_n(irq_a[i])
    );
  end

  assign l_int_n = irq_a[0];
  assign r_int_n = irq_a[1];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_ce,
  input logic              l_sem,
  input logic              l_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_ce,
  input logic              r_sem,
  input logic              r_wr,
  input logic              l_int_n,
  input logic              r_int_n
);
  logic [ADDR_W-1:0] lbox, rbox;
  assign rbox = '1;
  assign lbox = rbox - 1'b1;

  logic l_set, l_clr, r_set, r_clr;
  assign l_set = r_ce && !r_sem &&  r_wr && (r_addr == lbox);
  assign l_clr = l_ce && !l_sem && !l_wr && (l_addr == lbox);
  assign r_set = l_ce && !l_sem &&  l_wr && (l_addr == rbox);
  assign r_clr = r_ce && !r_sem && !r_wr && (r_addr == rbox);

  p_set_left_r1: assert property (@(posedge clk) disable iff (!rst_n) l_set |=> !l_int_n);
  p_clr_left_r2: assert property (@(posedge clk) disable iff (!rst_n) (l_clr && !l_set) |=> l_int_n);
  p_set_right_r3: assert property (@(posedge clk) disable iff (!rst_n) r_set |=> !r_int_n);
  p_clr_right_r4: assert property (@(posedge clk) disable iff (!rst_n) (r_clr && !r_set) |=> r_int_n);
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n) (l_set && l_clr) |=> !l_int_n);
  p_hold_left_r6: assert property (@(posedge clk) disable iff (!rst_n) (rst_n && !l_set && !l_clr) |=> $stable(l_int_n));
  p_hold_right_r7: assert property (@(posedge clk) disable iff (!rst_n) (rst_n && !r_set && !r_clr) |=> $stable(r_int_n));
  p_reset_r8: assert property (@(posedge clk) !rst_n |=> (l_int_n && r_int_n));
endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbx_irq_top.sv
module sim_mbx_irq_top;
  localparam int AW = 13;
  localparam time TCLK = 10ns;
  localparam logic [AW-1:0] LBOX = 13'h1FFE;
  localparam logic [AW-1:0] RBOX = 13'h1FFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_ce = 0, l_sem = 0, l_wr = 0, r_ce = 0, r_sem = 0, r_wr = 0;
  logic l_int_n, r_int_n;

  int n_tests = 0, n_fail = 0;
  bit m_l = 0, m_r = 0;   // model: flag pending

  always #(TCLK/2) clk = ~clk;

  mbx_irq_top #(.ADDR_W(AW)) u0 (.*);

  task automatic check(string req);
    n_tests++;
    if (l_int_n !== ~m_l || r_int_n !== ~m_r) begin
      n_fail++;
      $display("FAIL %s: l_int_n=%b r_int_n=%b expected %b %b", req, l_int_n, r_int_n, ~m_l, ~m_r);
    end
  endtask

  task automatic step(string req, logic rst, logic [AW-1:0] la, logic lc, logic ls, logic lw,
                      logic [AW-1:0] ra, logic rc, logic rs, logic rw);
    bit lact, ract, ls_set, ls_clr, rs_set, rs_clr;
    rst_n = rst; l_addr = la; l_ce = lc; l_sem = ls; l_wr = lw;
    r_addr = ra; r_ce = rc; r_sem = rs; r_wr = rw;
    @(posedge clk);
    lact = lc && !ls; ract = rc && !rs;
    ls_set = ract && rw && ra == LBOX;
    ls_clr = lact && !lw && la == LBOX;
    rs_set = lact && lw && la == RBOX;
    rs_clr = ract && !rw && ra == RBOX;
    if (!rst) begin m_l = 0; m_r = 0; end
    else begin
      if (ls_set) m_l = 1; else if (ls_clr) m_l = 0;
      if (rs_set) m_r = 1; else if (rs_clr) m_r = 0;
    end
    @(negedge clk);
    check(req);
  endtask

  initial begin
    #(TCLK*5000);
    n_fail++; n_tests++;
    $display("FAIL watchdog: expired, expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    step("R8 reset", 0, 0,0,0,0, 0,0,0,0);
    step("R8 reset", 0, 0,0,0,0, 0,0,0,0);
    // R1 / R2
    step("R1 right writes LBOX", 1, 0,0,0,0, LBOX,1,0,1);
    step("R7 idle hold", 1, 0,0,0,0, 0,0,0,0);
    step("R7 right reads LBOX no clear", 1, 0,0,0,0, LBOX,1,0,0);
    step("R7 left writes LBOX no clear", 1, LBOX,1,0,1, 0,0,0,0);
    step("R6 left read with sem", 1, LBOX,1,1,0, 0,0,0,0);
    step("R6 left read ce low", 1, LBOX,0,0,0, 0,0,0,0);
    step("R2 left reads LBOX", 1, LBOX,1,0,0, 0,0,0,0);
    // R3 / R4
    step("R6 left write RBOX ce low", 1, RBOX,0,0,1, 0,0,0,0);
    step("R6 left write RBOX sem", 1, RBOX,1,1,1, 0,0,0,0);
    step("R3 left writes RBOX", 1, RBOX,1,0,1, 0,0,0,0);
    step("R7 other address", 1, 13'h0123,1,0,0, 13'h1FFD,1,0,0);
    step("R4 right reads RBOX", 1, 0,0,0,0, RBOX,1,0,0);
    // R5 same-edge set/clear
    step("R5 left set and clear", 1, LBOX,1,0,0, LBOX,1,0,1);
    step("R5 right set and clear", 1, RBOX,1,0,1, RBOX,1,0,0);
    step("R2 clear after R5", 1, LBOX,1,0,0, 0,0,0,0);
    step("R8 reset clears both", 0, 0,0,0,0, 0,0,0,0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a0, a1;
      int k0 = $urandom_range(0, 3), k1 = $urandom_range(0, 3);
      a0 = (k0 == 0) ? LBOX : (k0 == 1) ? RBOX : AW'($urandom);
      a1 = (k1 == 0) ? LBOX : (k1 == 1) ? RBOX : AW'($urandom);
      step("R1 R2 R3 R4 R5 R6 random", ($urandom_range(0, 99) != 0),
           a0, 1'($urandom), ($urandom_range(0, 4) == 0), 1'($urandom),
           a1, 1'($urandom), ($urandom_range(0, 4) == 0), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule